// File: doc/BRIEF.md
# Bus Breakpoint Comparison Unit

This block watches a processor's address bus, data bus and read/write line and raises a break request when a programmed condition is met. Software sets it up through a small register port: a control register, a low-byte mask register and two 16-bit match registers (an address match register A and a second match register B). Every register can be read and written in any cycle.

A two-bit mode field picks the behaviour. In the full mode, register A must equal the address while register B equals the data, and a read/write direction can be required. In the two dual-address modes, A and B are both compared against the address, and either one matching is a hit. The direction is not checked in these modes. A program-only control bit selects when the break is taken. With the bit clear, a hit on any bus cycle arms a request that fires at the next instruction boundary. With the bit set, only opcode fetches are compared. Each fetched opcode's hit tag is carried down a small queue, and the request fires only when an execute strobe retires a tagged opcode.

Instruction queue, opcode decoder and debug interface lie outside the block. The block sees them only through the boundary, execute and flush strobes. Requests leave as one-cycle pulses, on the software-interrupt output in mode 01 and on the debug output in modes 10 and 11.

Top module: `bkpt_top`

## Requirements
- R1: After reset no request output is high. All four registers read zero, and a zero mode field means breakpoints are off.
- R2: Each register can be written when reg_we is high and read back combinationally on reg_rdata. The register is chosen by reg_sel: 0 is control, 1 is mask, 2 is match A, 3 is match B. The control register holds the mode in bits 1:0, program-only in bit 2, the direction-check enable in bit 3 and the required direction in bit 4 (1 = read). The mask register holds the low-byte ignore for A in bit 0 and for B in bit 1.
- R3: With mode 00 no bus activity and no strobe ever produces a request.
- R4: In modes 01 and 11 a bus cycle is a hit when its address equals match A or match B. The direction bits are ignored in these modes.
- R5: In mode 10 a bus cycle is a hit only when the address equals match A, the data equals match B, and, if the direction check is enabled, bus_rd equals the required direction.
- R6: When a comparator's mask bit is set, only bits 15..8 take part in that comparator's compare.
- R7: With program-only clear, a hit arms a pending break. A request pulse appears in the cycle after the first insn_bnd cycle that follows the hit cycle. Without a boundary, no request is made.
- R8: With program-only set, only bus cycles with bus_fetch high are compared, and each fetch enters a queue with its hit tag. A request pulse appears in the cycle after an exec_strobe that retires a tagged opcode. Untagged retirements, data accesses and instruction boundaries cause nothing. The queue keeps fetch order.
- R9: q_flush clears every queued tag, so a later execute strobe does not break.
- R10: Every request lasts one cycle per firing. It goes to swi_req in mode 01 and to dbg_req in modes 10 and 11, and the two outputs are never high together.
- R11: A control write that changes the mode field cancels any pending immediate break and all queued tags. The new mode governs bus cycles from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_fetch | input | 1 | Bus cycle is an opcode fetch |
| insn_bnd | input | 1 | Instruction boundary strobe |
| exec_strobe | input | 1 | Oldest queued opcode executes |
| q_flush | input | 1 | Instruction queue flush |
| swi_req | output | 1 | Software-interrupt break pulse |
| dbg_req | output | 1 | Debug break pulse |

## Verification
The bench builds the unit with 16-bit registers and a three-entry tag queue, instead of the default four. This lets a short directed sequence fill the queue and retire an older untagged opcode ahead of a tagged one, which checks that tags keep fetch order. The 16-bit width keeps the 8-bit low-byte mask split, so the masked compares use real address values. Every mode is driven with hits on each comparator, near misses, direction qualifiers and mode-change cancellation of both the armed and the queued break paths.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_SWI_DUAL = 2'b01,
        MODE_DBG_FULL = 2'b10,
        MODE_DBG_DUAL = 2'b11
    } brk_mode_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_MA   = 2'd2;
    localparam logic [1:0] SEL_MB   = 2'd3;

    // bit 0..1 mode, bit 2 program-only, bit 3 direction check, bit 4 direction
    typedef struct packed {
        logic      dir_is_rd;
        logic      dir_chk;
        logic      prog_only;
        brk_mode_e mode;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

    typedef struct packed {
        logic pend;
        logic swi;
        logic dbg;
    } core_t;

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output ctrl_t        ctrl,
    output logic         ign_a,
    output logic         ign_b,
    output logic [W-1:0] match_a,
    output logic [W-1:0] match_b,
    output logic         mode_chg
);

    typedef struct packed {
        ctrl_t        ctrl;
        logic         ign_a;
        logic         ign_b;
        logic [W-1:0] ma;
        logic [W-1:0] mb;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL: r_d.ctrl = ctrl_t'(wr_data[CTRL_BITS-1:0]);
                SEL_MASK: begin
                    r_d.ign_a = wr_data[0];
                    r_d.ign_b = wr_data[1];
                end
                SEL_MA:   r_d.ma = wr_data;
                default:  r_d.mb = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rd_data = W'(r_q.ctrl);
            SEL_MASK: rd_data = W'({r_q.ign_b, r_q.ign_a});
            SEL_MA:   rd_data = r_q.ma;
            default:  rd_data = r_q.mb;
        endcase
    end

    assign mode_chg = wr_en && (sel == SEL_CTRL) && (wr_data[1:0] != r_q.ctrl.mode);
    assign ctrl     = r_q.ctrl;
    assign ign_a    = r_q.ign_a;
    assign ign_b    = r_q.ign_b;
    assign match_a  = r_q.ma;
    assign match_b  = r_q.mb;

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
    parameter int W  = 16,
    parameter int LO = W / 2
) (
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] cand,
    input  logic         ign_lo,
    output logic         eq
);

    logic hi_eq, lo_eq;

    assign hi_eq = (ref_val[W-1:LO] == cand[W-1:LO]);
    assign lo_eq = ign_lo || (ref_val[LO-1:0] == cand[LO-1:0]);
    assign eq    = hi_eq && lo_eq;

endmodule

// File: rtl/bkpt_tagq.sv
module bkpt_tagq #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_tag,
    input  logic          pop,
    input  logic          clr,
    output logic          pop_hit,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0] tags;
        logic [CW-1:0]    cnt;
    } q_t;

    q_t q_d, q_q;
    logic [CW-1:0] cnt_mid;

    always_comb begin
        q_d     = q_q;
        cnt_mid = q_q.cnt;
        if (pop && q_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) q_d.tags[i] = q_q.tags[i+1];
            q_d.tags[DEPTH-1] = 1'b0;
            cnt_mid = q_q.cnt - 1'b1;
        end
        q_d.cnt = cnt_mid;
        if (push && int'(cnt_mid) < DEPTH) begin
            for (int i = 0; i < DEPTH; i++)
                if (i == int'(cnt_mid)) q_d.tags[i] = push_tag;
            q_d.cnt = cnt_mid + 1'b1;
        end
        if (clr) q_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign pop_hit = pop && !clr && (q_q.cnt != '0) && q_q.tags[0];
    assign count   = q_q.cnt;

endmodule

// File: rtl/bkpt_top.sv
module bkpt_top
    import bkpt_pkg::*;
#(
    parameter int W      = 16,
    parameter int QDEPTH = 4,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         bus_valid,
    input  logic [W-1:0] bus_addr,
    input  logic [W-1:0] bus_data,
    input  logic         bus_rd,
    input  logic         bus_fetch,
    input  logic         insn_bnd,
    input  logic         exec_strobe,
    input  logic         q_flush,
    output logic         swi_req,
    output logic         dbg_req
);

    ctrl_t         ctrl;
    logic          ign_a, ign_b, mode_chg;
    logic [W-1:0]  match_a, match_b, b_src;
    logic          a_eq, b_eq;
    logic          active, dir_ok, hit, imm_hit, fire, pop_hit;
    logic [CW-1:0] q_cnt;
    core_t         st_d, st_q;

    bkpt_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(reg_sel),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .ctrl(ctrl),
        .ign_a(ign_a), .ign_b(ign_b), .match_a(match_a), .match_b(match_b),
        .mode_chg(mode_chg)
    );

    assign b_src = (ctrl.mode == MODE_DBG_FULL) ? bus_data : bus_addr;

    bkpt_cmp #(.W(W)) u_cmp_a (
        .ref_val(match_a), .cand(bus_addr), .ign_lo(ign_a), .eq(a_eq)
    );

    bkpt_cmp #(.W(W)) u_cmp_b (
        .ref_val(match_b), .cand(b_src), .ign_lo(ign_b), .eq(b_eq)
    );

    assign active  = bus_valid && (ctrl.mode != MODE_OFF) && (!ctrl.prog_only || bus_fetch);
    assign dir_ok  = !ctrl.dir_chk || (bus_rd == ctrl.dir_is_rd);
    assign hit     = active && ((ctrl.mode == MODE_DBG_FULL) ? (a_eq && b_eq && dir_ok)
                                                              : (a_eq || b_eq));
    assign imm_hit = hit && !ctrl.prog_only;

    bkpt_tagq #(.DEPTH(QDEPTH)) u_tagq (
        .clk(clk), .rst_n(rst_n),
        .push(bus_valid && bus_fetch), .push_tag(hit && ctrl.prog_only),
        .pop(exec_strobe), .clr(q_flush || mode_chg),
        .pop_hit(pop_hit), .count(q_cnt)
    );

    assign fire = !mode_chg && ((st_q.pend && insn_bnd) || pop_hit);

    always_comb begin
        st_d      = st_q;
        st_d.pend = mode_chg ? 1'b0 : (imm_hit || (st_q.pend && !insn_bnd));
        st_d.swi  = fire && (ctrl.mode == MODE_SWI_DUAL);
        st_d.dbg  = fire && ctrl.mode[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign swi_req = st_q.swi;
    assign dbg_req = st_q.dbg;

endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          cancel,
    input logic          flush,
    input logic          bnd,
    input logic          exec,
    input logic          swi,
    input logic          dbg,
    input logic [CW-1:0] q_cnt
);

    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (!swi && !dbg));

    p_strobe_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (swi || dbg) |-> ($past(bnd) || $past(exec)));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_cnt == '0));

    p_excl_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(swi && dbg));

    p_swi_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swi |-> ($past(mode) == 2'b01));

    p_dbg_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg |-> $past(mode[1]));

    p_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!swi && !dbg && q_cnt == '0));

endmodule

bind bkpt_top bkpt_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .cancel(mode_chg),
    .flush(q_flush), .bnd(insn_bnd), .exec(exec_strobe),
    .swi(swi_req), .dbg(dbg_req), .q_cnt(q_cnt)
);

// File: tb/tb_bkpt_top.sv
`timescale 1ns/1ps
module tb_bkpt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_valid = 1'b0, bus_rd = 1'b0, bus_fetch = 1'b0;
    logic [15:0] bus_addr = '0, bus_data = '0;
    logic        insn_bnd = 1'b0, exec_strobe = 1'b0, q_flush = 1'b0;
    logic        swi_req, dbg_req;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bkpt_top #(.W(16), .QDEPTH(3)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd),
        .bus_fetch(bus_fetch), .insn_bnd(insn_bnd), .exec_strobe(exec_strobe),
        .q_flush(q_flush), .swi_req(swi_req), .dbg_req(dbg_req)
    );

    task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [15:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        step();
        reg_we = 1'b0;
    endtask

    // mode | prog<<2 | dirchk<<3 | dir_rd<<4
    function automatic logic [15:0] cw(input logic [1:0] m, input logic p, input logic dc, input logic dr);
        return {11'd0, dr, dc, p, m};
    endfunction

    // one bus/strobe cycle; outputs sampled after the edge that registers it
    task automatic cyc(input logic v, input logic [15:0] a, input logic [15:0] d,
                       input logic rd, input logic f, input logic bnd, input logic ex, input logic fl);
        bus_valid = v; bus_addr = a; bus_data = d; bus_rd = rd; bus_fetch = f;
        insn_bnd = bnd; exec_strobe = ex; q_flush = fl;
        step();
        bus_valid = 0; bus_fetch = 0; insn_bnd = 0; exec_strobe = 0; q_flush = 0;
    endtask

    task automatic expect_out(input string req, input string what, input logic s, input logic d);
        check(req, {what, " swi"}, {15'd0, swi_req}, {15'd0, s});
        check(req, {what, " dbg"}, {15'd0, dbg_req}, {15'd0, d});
    endtask

    // bus cycle then boundary; expect result on boundary's following cycle
    task automatic imm_try(input string req, input string what, input logic [15:0] a, input logic [15:0] d,
                           input logic rd, input logic s, input logic db);
        cyc(1, a, d, rd, 0, 0, 0, 0);
        expect_out(req, {what, " after bus"}, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out(req, what, s, db);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        expect_out(req, {what, " pulse ends"}, 0, 0);
    endtask

    task automatic t_reset();
        expect_out("R1", "reset", 0, 0);
        for (int s = 0; s < 4; s++) begin
            reg_sel = s[1:0]; #1;
            check("R1", "reg reset", reg_rdata, 16'h0000);
        end
    endtask

    task automatic t_regs();
        wreg(2'd2, 16'hA5C3); wreg(2'd3, 16'h3C5A); wreg(2'd1, 16'h0003);
        wreg(2'd0, cw(2'b00, 1, 1, 1));
        reg_sel = 2'd0; #1; check("R2", "ctrl", reg_rdata, 16'h001C);
        reg_sel = 2'd1; #1; check("R2", "mask", reg_rdata, 16'h0003);
        reg_sel = 2'd2; #1; check("R2", "match A", reg_rdata, 16'hA5C3);
        reg_sel = 2'd3; #1; check("R2", "match B", reg_rdata, 16'h3C5A);
        wreg(2'd1, 16'h0000);
        wreg(2'd0, cw(2'b00, 0, 0, 0));
    endtask

    task automatic t_off();
        wreg(2'd2, 16'h1234); wreg(2'd3, 16'h5678);
        imm_try("R3", "off mode addr hit", 16'h1234, 16'h5678, 1, 0, 0);
        cyc(1, 16'h1234, 0, 0, 1, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 1, 0);
        expect_out("R3", "off mode strobes", 0, 0);
    endtask

    task automatic t_swi_dual();
        wreg(2'd0, cw(2'b01, 0, 1, 1));
        imm_try("R4", "dual A hit (R10 swi)", 16'h1234, 0, 0, 1, 0);
        imm_try("R4", "dual B hit write", 16'h5678, 0, 0, 1, 0);
        imm_try("R4", "dual miss", 16'h1235, 0, 1, 0, 0);
        // R7: no boundary, no request
        cyc(1, 16'h1234, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 0);
            expect_out("R7", "armed, no boundary", 0, 0);
        end
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R7", "late boundary", 1, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R7", "second boundary no repeat", 0, 0);
        // R7: hit and boundary in same cycle fires at the following boundary
        cyc(1, 16'h1234, 0, 1, 0, 1, 0, 0);
        expect_out("R7", "same-cycle boundary", 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R7", "next boundary", 1, 0);
    endtask

    task automatic t_full();
        wreg(2'd0, cw(2'b10, 0, 0, 0));
        wreg(2'd2, 16'h2000); wreg(2'd3, 16'h00AB);
        imm_try("R5", "full addr only", 16'h2000, 16'h00AC, 1, 0, 0);
        imm_try("R5", "full data only", 16'h2001, 16'h00AB, 1, 0, 0);
        imm_try("R5", "full both (R10 dbg)", 16'h2000, 16'h00AB, 1, 0, 1);
        wreg(2'd0, cw(2'b10, 0, 1, 0));
        imm_try("R5", "full wrong dir", 16'h2000, 16'h00AB, 1, 0, 0);
        imm_try("R5", "full write ok", 16'h2000, 16'h00AB, 0, 0, 1);
        wreg(2'd0, cw(2'b11, 0, 1, 0));
        wreg(2'd3, 16'h3000);
        imm_try("R4", "dbg dual B, dir ignored", 16'h3000, 0, 1, 0, 1);
    endtask

    task automatic t_mask();
        wreg(2'd0, cw(2'b01, 0, 0, 0));
        wreg(2'd2, 16'h12FF); wreg(2'd3, 16'h7777);
        imm_try("R6", "A lo unmasked", 16'h1200, 0, 1, 0, 0);
        wreg(2'd1, 16'h0001);
        imm_try("R6", "A lo masked", 16'h1200, 0, 1, 1, 0);
        imm_try("R6", "A hi differs", 16'h1300, 0, 1, 0, 0);
        wreg(2'd1, 16'h0002);
        imm_try("R6", "B lo masked", 16'h7700, 0, 1, 1, 0);
        wreg(2'd1, 16'h0000);
    endtask

    task automatic t_prog();
        wreg(2'd0, cw(2'b11, 1, 0, 0));
        wreg(2'd2, 16'h4000); wreg(2'd3, 16'hFFFF);
        cyc(1, 16'h4000, 0, 1, 0, 1, 0, 0);           // data access at match
        cyc(1, 16'h4000, 0, 1, 1, 1, 0, 0);           // tagged fetch
        expect_out("R8", "boundary ignored", 0, 0);
        cyc(1, 16'h4002, 0, 1, 1, 0, 0, 0);           // untagged fetch
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R8", "boundary no break", 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_out("R8", "tagged retire", 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_out("R8", "untagged retire", 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_out("R8", "empty queue retire", 0, 0);
        // order: untagged, untagged, tagged in a full 3-deep queue
        cyc(1, 16'h5000, 0, 1, 1, 0, 0, 0);
        cyc(1, 16'h5001, 0, 1, 1, 0, 0, 0);
        cyc(1, 16'h4000, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0); expect_out("R8", "order 1st", 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0); expect_out("R8", "order 2nd", 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 0); expect_out("R8", "order 3rd tagged", 0, 1);
    endtask

    task automatic t_flush();
        cyc(1, 16'h4000, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_out("R9", "retire after flush", 0, 0);
    endtask

    task automatic t_cancel();
        // queued tag cancelled by mode change 11 -> 10
        cyc(1, 16'h4000, 0, 1, 1, 0, 0, 0);
        wreg(2'd0, cw(2'b10, 1, 0, 0));
        cyc(0, 0, 0, 0, 0, 0, 1, 0);
        expect_out("R11", "queued tag cancelled", 0, 0);
        // armed immediate break cancelled by mode change 01 -> 11
        wreg(2'd0, cw(2'b01, 0, 0, 0));
        cyc(1, 16'h4000, 0, 1, 0, 0, 0, 0);
        wreg(2'd0, cw(2'b11, 0, 0, 0));
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        expect_out("R11", "armed break cancelled", 0, 0);
        // new mode in force on the next bus cycle
        imm_try("R11", "new mode routes dbg", 16'h4000, 0, 1, 0, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_off();
        t_swi_dual();
        t_full();
        t_mask();
        t_prog();
        t_flush();
        t_cancel();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule